// File: doc/BRIEF.md
# Resource Descriptor ID Extractor

This block walks the byte stream of plug-and-play resource descriptors that a card returns and extracts the identifier items from it. Bytes are pulled one per cycle: the source raises `rd_avail` when a byte is ready on `rd_byte`, and the block answers with `rd_ack` in the same cycle to consume it at the next rising clock edge. Each descriptor begins with a tag byte. The tag is either a small item, which carries its type and a 3-bit length in the tag itself, or a large item, which is followed by a 16-bit length.

Items that carry a logical-device identifier or a compatible-device identifier are collected into a 32-bit word, with the first payload byte in the lowest bits. The word is announced with a one-cycle `id_valid` pulse. All other items, small or large, are read and discarded byte by byte. Parsing goes on through later items until an end marker is seen. After that, `stream_end` stays high and the block stops taking bytes until reset.

Top module: `rdx_id_extractor`

## Requirements
- R1: `rd_ack` is high only in a cycle where `rd_avail` is high, and each cycle with `rd_ack` high consumes exactly one byte at the following rising edge.
- R2: A tag byte with bit 7 clear is a small item with type in bits [6:3] and payload length in bits [2:0]. A small item whose type is not 0x2, 0x3 or 0xF has its payload bytes consumed without being interpreted, even when they look like tags.
- R3: A tag byte with bit 7 set (other than 0xFF) is a large item. The next two bytes form a 16-bit length, low byte first, and that many following bytes are consumed and discarded. A length of zero discards nothing.
- R4: A small tag of type 0xF (any length bits) or the byte 0xFF ends the stream. `stream_end` rises in the cycle after that tag is consumed and stays high until reset.
- R5: Small items of type 0x2 and 0x3 are identifier items. One cycle after the last payload byte of such an item is consumed, `id_valid` is high for exactly one cycle, and `id_value` holds payload byte 0 in bits [7:0], byte 1 in [15:8], byte 2 in [23:16] and byte 3 in [31:24].
- R6: An identifier payload longer than four bytes yields only its first four bytes in `id_value`. The remaining bytes are still consumed and dropped.
- R7: An identifier payload of one to three bytes yields zero in the byte lanes it does not fill. An identifier item of length zero produces no `id_valid` pulse.
- R8: After an identifier is emitted, parsing continues with the next tag. Several identifiers in one stream are each emitted once, in stream order.
- R9: Once the end marker is consumed, `rd_ack` stays low, so no byte after the end marker is consumed.
- R10: While reset is applied, `rd_ack`, `id_valid` and `stream_end` are low. After reset, the first byte consumed is taken as a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_avail | input | 1 | A descriptor byte is ready on `rd_byte` |
| rd_byte | input | 8 | Descriptor byte from the source |
| rd_ack | output | 1 | Byte is consumed at the next rising edge |
| id_value | output | 32 | Last extracted identifier, first byte least significant |
| id_valid | output | 1 | One-cycle pulse when `id_value` is updated |
| stream_end | output | 1 | End marker seen; no more bytes are consumed |

## Verification
A parser that is in the wrong state, or that holds a wrong skip count, gets out of step with the item boundaries. A payload byte is then taken as a tag, or a tag is swallowed as payload. At the ports this shows up as a wrong number of consumed bytes when the end marker is reached, a missing or extra `id_valid` pulse, or an `id_value` with its bytes shifted. Each stimulus stream therefore places decoy bytes that look like identifier or end tags inside skipped payloads and after the end marker. A single miscount changes the consumed-byte total and the end flag within that same stream. Stalls on `rd_avail` are mixed in, so that a count which advances without a handshake also shifts the results.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

  typedef enum logic [2:0] {
    ST_TAG    = 3'd0,
    ST_LEN_LO = 3'd1,
    ST_LEN_HI = 3'd2,
    ST_SKIP   = 3'd3,
    ST_PAY    = 3'd4,
    ST_DONE   = 3'd5
  } rdx_state_e;

  localparam logic [3:0] SMALL_LDEV_ID = 4'h2;
  localparam logic [3:0] SMALL_CDEV_ID = 4'h3;
  localparam logic [3:0] SMALL_END     = 4'hF;
  localparam logic [7:0] LARGE_END     = 8'hFF;

  typedef struct packed {
    logic       is_large;
    logic       is_end;
    logic       is_id;
    logic [2:0] small_len;
  } rdx_tag_t;

endpackage

// File: rtl/rdx_tag_decode.sv
module rdx_tag_decode
  import rdx_pkg::*;
(
  input  logic [7:0] tag,
  output rdx_tag_t   dec
);

  logic [3:0] small_type;

  always_comb begin
    small_type    = tag[6:3];
    dec.is_large  = tag[7];
    dec.small_len = tag[2:0];
    if (tag[7]) begin
      dec.is_end = (tag == LARGE_END);
      dec.is_id  = 1'b0;
    end else begin
      dec.is_end = (small_type == SMALL_END);
      dec.is_id  = (small_type == SMALL_LDEV_ID) || (small_type == SMALL_CDEV_ID);
    end
  end

endmodule

// File: rtl/rdx_span_counter.sv
module rdx_span_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

  // R3: a decrement never happens on an empty span
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));

  // R2: a span is never loaded while it is still being consumed
  a_r2_load_dec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && dec));

endmodule

// File: rtl/rdx_id_assemble.sv
module rdx_id_assemble #(
  parameter int ID_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  wr_en,
  input  logic [7:0]            wr_byte,
  input  logic                  emit,
  output logic [8*ID_BYTES-1:0] id_value,
  output logic                  id_valid
);

  localparam int IDX_W = $clog2(ID_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(ID_BYTES);

  logic [ID_BYTES-1:0][7:0] acc_q, acc_d;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic [8*ID_BYTES-1:0]    val_q, val_d;
  logic                     vld_q, vld_d;

  always_comb begin
    acc_d = acc_q;
    idx_d = idx_q;
    if (clear) begin
      acc_d = '0;
      idx_d = '0;
    end else if (wr_en) begin
      for (int g = 0; g < ID_BYTES; g++) begin
        if (idx_q == IDX_W'(g)) acc_d[g] = wr_byte;
      end
      if (idx_q != IDX_FULL) idx_d = idx_q + IDX_W'(1);
    end
    vld_d = emit;
    val_d = emit ? acc_d : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
      val_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (clear || wr_en) begin
        acc_q <= acc_d;
        idx_q <= idx_d;
      end
      if (emit) val_q <= val_d;
      vld_q <= vld_d;
    end
  end

  assign id_value = val_q;
  assign id_valid = vld_q;

  // R6: the lane index saturates at the identifier width
  a_r6_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_FULL);

  // R5: an identifier is only published together with its last payload byte
  a_r5_emit_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> wr_en);

endmodule

// File: rtl/rdx_id_extractor.sv
module rdx_id_extractor
  import rdx_pkg::*;
#(
  parameter int ID_BYTES = 4,
  parameter int LEN_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_avail,
  input  logic [7:0]            rd_byte,
  output logic                  rd_ack,
  output logic [8*ID_BYTES-1:0] id_value,
  output logic                  id_valid,
  output logic                  stream_end
);

  logic [1:0]  rst_sync_q;
  logic        rst_n_s;
  rdx_state_e  state_q, state_d;
  logic [7:0]  len_lo_q, len_lo_d;
  rdx_tag_t    tag_dec;
  logic        take;
  logic        cnt_load, cnt_dec, cnt_last;
  logic [LEN_W-1:0] cnt_val;
  logic        id_clear, id_wr, id_emit;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  rdx_tag_decode u_tag_decode (
    .tag (rd_byte),
    .dec (tag_dec)
  );

  assign take       = rd_avail && rst_n_s && (state_q != ST_DONE);
  assign rd_ack     = take;
  assign stream_end = (state_q == ST_DONE);

  always_comb begin
    state_d  = state_q;
    len_lo_d = len_lo_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    id_clear = 1'b0;
    id_wr    = 1'b0;
    id_emit  = 1'b0;
    if (take) begin
      unique case (state_q)
        ST_TAG: begin
          if (tag_dec.is_end) begin
            state_d = ST_DONE;
          end else if (tag_dec.is_large) begin
            state_d = ST_LEN_LO;
          end else if (tag_dec.small_len != 3'd0) begin
            cnt_load = 1'b1;
            cnt_val  = LEN_W'(tag_dec.small_len);
            if (tag_dec.is_id) begin
              id_clear = 1'b1;
              state_d  = ST_PAY;
            end else begin
              state_d  = ST_SKIP;
            end
          end
        end
        ST_LEN_LO: begin
          len_lo_d = rd_byte;
          state_d  = ST_LEN_HI;
        end
        ST_LEN_HI: begin
          if ({rd_byte, len_lo_q} == 16'h0000) begin
            state_d = ST_TAG;
          end else begin
            cnt_load = 1'b1;
            cnt_val  = LEN_W'({rd_byte, len_lo_q});
            state_d  = ST_SKIP;
          end
        end
        ST_SKIP: begin
          cnt_dec = 1'b1;
          if (cnt_last) state_d = ST_TAG;
        end
        ST_PAY: begin
          cnt_dec = 1'b1;
          id_wr   = 1'b1;
          if (cnt_last) begin
            id_emit = 1'b1;
            state_d = ST_TAG;
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_TAG;
      len_lo_q <= '0;
    end else if (take) begin
      state_q  <= state_d;
      len_lo_q <= len_lo_d;
    end
  end

  rdx_span_counter #(.CNT_W(LEN_W)) u_span (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  rdx_id_assemble #(.ID_BYTES(ID_BYTES)) u_assemble (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clear    (id_clear),
    .wr_en    (id_wr),
    .wr_byte  (rd_byte),
    .emit     (id_emit),
    .id_value (id_value),
    .id_valid (id_valid)
  );

  // R1: consumption only on an offered byte
  a_r1_ack_needs_ready: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_ack |-> rd_avail);

  // R4: the end flag holds until reset
  a_r4_end_holds: assert property (@(posedge clk) disable iff (!rst_n_s)
    stream_end |=> stream_end);

  // R9: nothing is consumed after the end marker
  a_r9_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n_s)
    stream_end |-> !rd_ack);

  // R8: identifiers are separate single-cycle pulses
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    id_valid |=> !id_valid);

  // R5: a pulse follows a cycle spent in an identifier payload
  a_r5_pulse_after_payload: assert property (@(posedge clk) disable iff (!rst_n_s)
    id_valid |-> ($past(state_q) == ST_PAY));

endmodule

// File: tb/test_rdx_id_extractor.sv
module test_rdx_id_extractor;

  typedef struct packed {
    logic [127:0] bytes;   // byte k at [8k+7:8k]
    logic [4:0]   nbytes;
    logic [4:0]   used;
    logic [1:0]   nids;
    logic [31:0]  id0;
    logic [31:0]  id1;
    logic         stall;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    // id type 2 len 5, end 0x79, trailing decoy
    '{128'hAA79_0102_0CD0_4115, 5'd8, 5'd7, 2'd1, 32'h020CD041, 32'h0, 1'b0},
    // id type 3 len 4, end 0x78
    '{128'h5578_DDCC_BBAA_1C, 5'd7, 5'd6, 2'd1, 32'hDDCCBBAA, 32'h0, 1'b0},
    // small skip then id
    '{128'h0079_0403_0201_1C22_1122, 5'd10, 5'd9, 2'd1, 32'h04030201, 32'h0, 1'b0},
    // large skip hiding fake tags, then id, end 0xFF
    '{128'h00FF_4030_2010_1C41_15AA_0003_82, 5'd13, 5'd12, 2'd1, 32'h40302010, 32'h0, 1'b0},
    // two ids, first short
    '{128'hEE78_0403_0201_1C12_3412, 5'd10, 5'd9, 2'd2, 32'h00001234, 32'h04030201, 1'b0},
    // large len 0, id len 0, end
    '{128'h3378_1000_0081, 5'd6, 5'd5, 2'd0, 32'h0, 32'h0, 1'b0},
    // two ids with stalls
    '{128'hEE78_0403_0201_1C12_3412, 5'd10, 5'd9, 2'd2, 32'h00001234, 32'h04030201, 1'b1},
    // immediate large end
    '{128'h15FF, 5'd2, 5'd1, 2'd0, 32'h0, 32'h0, 1'b0},
    // small skip of 7 then short id, with stalls
    '{128'h790C_0B0A_1B07_0605_0403_0201_3F, 5'd13, 5'd13, 2'd1, 32'h000C0B0A, 32'h0, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        rd_avail;
  logic [7:0]  rd_byte;
  logic        rd_ack;
  logic [31:0] id_value;
  logic        id_valid;
  logic        stream_end;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_seen = 0;
  logic [31:0] seen [4];
  logic [7:0]  src [300];
  int src_len = 0;
  bit stall = 0;
  int consumed = 0;

  rdx_id_extractor i_rdx_id_extractor (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_avail   (rd_avail),
    .rd_byte    (rd_byte),
    .rd_ack     (rd_ack),
    .id_value   (id_value),
    .id_valid   (id_valid),
    .stream_end (stream_end)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && id_valid) begin
      if (n_seen < 4) seen[n_seen] = id_value;
      n_seen = n_seen + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    rd_avail = 1'b1;
    rd_byte  = 8'h15;
    repeat (2) @(negedge clk);
    check("R10 ack in reset", 32'(rd_ack), 32'd0);
    check("R10 end in reset", 32'(stream_end), 32'd0);
    check("R10 valid in reset", 32'(id_valid), 32'd0);
    rd_avail = 1'b0;
    rst_n    = 1'b1;
    repeat (3) @(negedge clk);
    n_seen   = 0;
    consumed = 0;
  endtask

  task automatic feed();
    int idx = 0;
    for (int c = 0; c < src_len * 3 + 8; c++) begin
      @(negedge clk);
      rd_avail = (idx < src_len) && !(stall && (c % 3 == 2));
      rd_byte  = (idx < src_len) ? src[idx] : 8'h00;
      #1;
      if (rd_ack) begin
        if (!rd_avail) check("R1 ack without byte", 32'(rd_ack), 32'd0);
        consumed = consumed + 1;
        idx = idx + 1;
      end
    end
    @(negedge clk);
    rd_avail = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic verify(input string req, input int used, input int nids,
                        input logic [31:0] id0, input logic [31:0] id1);
    check("R9 bytes consumed", 32'(consumed), 32'(used));
    check("R4 end flag", 32'(stream_end), 32'd1);
    check("R8 identifier count", 32'(n_seen), 32'(nids));
    if (nids > 0 && n_seen > 0) check(req, seen[0], id0);
    if (nids > 1 && n_seen > 1) check(req, seen[1], id1);
  endtask

  initial begin
    rst_n    = 1'b0;
    rd_avail = 1'b0;
    rd_byte  = 8'h00;

    // table walk; values checked under R5
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      for (int k = 0; k < 16; k++) src[k] = VECS[v].bytes[8*k +: 8];
      src_len = int'(VECS[v].nbytes);
      stall   = VECS[v].stall;
      feed();
      verify("R5 identifier value", int'(VECS[v].used), int'(VECS[v].nids),
             VECS[v].id0, VECS[v].id1);
    end

    // R3: large item of 256 bytes full of fake id tags
    do_reset();
    src[0] = 8'h83; src[1] = 8'h00; src[2] = 8'h01;
    for (int k = 3; k < 259; k++) src[k] = 8'h1C;
    src[259] = 8'h14; src[260] = 8'h11; src[261] = 8'h22;
    src[262] = 8'h33; src[263] = 8'h44; src[264] = 8'h79; src[265] = 8'h14;
    src_len = 266; stall = 1'b0;
    feed();
    verify("R3 id after large skip", 265, 1, 32'h44332211, 32'h0);

    // R6: seven-byte identifier truncated to four
    do_reset();
    src[0] = 8'h17;
    for (int k = 1; k < 8; k++) src[k] = 8'hA0 + 8'(k);
    src[8] = 8'h79; src[9] = 8'h14;
    src_len = 10; stall = 1'b1;
    feed();
    verify("R6 truncated identifier", 9, 1, 32'hA4A3A2A1, 32'h0);

    // R7: one-byte identifier zero filled, zero-length identifier silent
    do_reset();
    src[0] = 8'h19; src[1] = 8'h5A; src[2] = 8'h10; src[3] = 8'h78; src[4] = 8'h1C;
    src_len = 5; stall = 1'b0;
    feed();
    verify("R7 short identifier", 4, 1, 32'h0000005A, 32'h0);

    // R2: vendor small item hides end-like bytes
    do_reset();
    src[0] = 8'h72; src[1] = 8'hFF; src[2] = 8'h79; src[3] = 8'h78; src[4] = 8'h15;
    src_len = 5; stall = 1'b0;
    feed();
    verify("R2 small skip", 4, 0, 32'h0, 32'h0);

    // R4: small end tag with nonzero length bits
    do_reset();
    src[0] = 8'h7F; src[1] = 8'h1C; src[2] = 8'h01;
    src_len = 3; stall = 1'b0;
    feed();
    verify("R4 end tag", 1, 0, 32'h0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule